// File: doc/BRIEF.md
# Multi-Channel DMA Programming Front End

This block is the register-programming side of a DMA controller with up to sixteen channels. A host reaches it through two byte-wide ports. A write to the command port selects an operation and a channel. Data-port writes that follow then fill the selected channel's fields one byte at a time. A byte pointer advances by itself after each byte and restarts on every new command. Data-port reads return a channel's current address, its remaining count, or a small status byte, in the same low-byte-first order.

Each channel holds a 24-bit address, a 16-bit count, a 16-bit I/O port number, a mode byte, a mask bit and a terminal-count flag. The bus-mastering engine is outside this block. It appears here only as a strobe and a channel number. Each accepted strobe steps that channel's address and count. The engine reads the settings of the channel it names back through a set of combinational outputs. Software masks a channel, writes its mode, address and count, and then unmasks it.

Top module: `dmac_cmd_port`

## Requirements
- R1: A command-port byte carries the opcode in bits 7:4 and the channel in bits 3:0. Every command write returns the data-port byte pointer to zero. The opcodes are 0x0 set I/O port, 0x2 set address, 0x3 get address, 0x4 set count, 0x5 get count, 0x6 get status, 0x7 set mode, 0x9 mask, 0xA unmask and 0xD master clear.
- R2: After opcode 0x2, three data writes load address bits 7:0, then 15:8, then 23:16.
- R3: After opcode 0x4, two data writes load count bits 7:0, then 15:8. Writing either count byte clears that channel's terminal-count flag.
- R4: Opcode 0x0 takes two data bytes, low byte first, as the I/O port number. Opcode 0x7 takes one mode byte: bit 0 targets an I/O register, bit 2 enables transfers, bit 3 selects read (clear selects write), and bit 6 selects 16-bit transfers. These settings appear on the eng_* outputs for the channel on xfer_chan. eng_go is high when that channel is unmasked and has bit 2 set.
- R5: Data writes past the field length are ignored. Data writes after a get, mask, unmask, master-clear or unassigned opcode are also ignored.
- R6: After opcode 0x3, dat_rdata shows address bits 7:0, then 15:8, then 23:16. After opcode 0x5, it shows count bits 7:0, then 15:8. Each dat_re pulse advances the byte. Once the field is used up, dat_rdata reads 0x00.
- R7: After opcode 0x6, dat_rdata shows bit 0 = mask and bit 1 = terminal-count flag, with the other bits zero.
- R8: Opcode 0x9 sets and opcode 0xA clears the named channel's mask bit. After reset every mask bit is set.
- R9: Master clear zeroes every channel's address, count, I/O port, mode and terminal-count flag, and sets every mask bit.
- R10: A strobe on an unmasked channel whose mode bit 2 is set adds 1 to the address (2 when mode bit 6 is set) and subtracts 1 from the count. Otherwise the strobe changes nothing.
- R11: A strobe accepted while the count is zero wraps the count to 0xFFFF and sets that channel's terminal-count flag.
- R12: If a data write lands on a channel in the same cycle as a strobe to that channel, the write takes effect and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command-port write strobe |
| cmd_wdata | input | 8 | Command byte: opcode and channel |
| dat_we | input | 1 | Data-port write strobe |
| dat_wdata | input | 8 | Data-port write byte |
| dat_re | input | 1 | Data-port read strobe; advances the byte pointer |
| dat_rdata | output | 8 | Data-port read byte |
| xfer_stb | input | 1 | Transfer step from the engine |
| xfer_chan | input | CHW | Channel named by the engine |
| eng_go | output | 1 | Named channel unmasked and enabled |
| eng_word | output | 1 | Named channel uses 16-bit transfers |
| eng_read | output | 1 | Named channel direction is read |
| eng_io | output | 1 | Named channel targets an I/O register |
| eng_ioport | output | 16 | Named channel's I/O port number |
| mask_o | output | NCH | Mask bit per channel |
| tc_o | output | NCH | Terminal-count flag per channel |

## Verification
The assertions assume the host never raises cmd_we and dat_we in the same cycle. They also assume xfer_chan names an implemented channel. The bench drives each port strobe alone and draws channel numbers only from 0 to NCH-1. The one deliberate overlap is a data write together with a strobe. The bench uses it only to exercise the priority rule. It checks the address byte that was written and checks that the count did not move.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam logic [3:0] OP_SET_IO   = 4'h0;
    localparam logic [3:0] OP_SET_ADDR = 4'h2;
    localparam logic [3:0] OP_GET_ADDR = 4'h3;
    localparam logic [3:0] OP_SET_CNT  = 4'h4;
    localparam logic [3:0] OP_GET_CNT  = 4'h5;
    localparam logic [3:0] OP_GET_STAT = 4'h6;
    localparam logic [3:0] OP_SET_MODE = 4'h7;
    localparam logic [3:0] OP_MASK     = 4'h9;
    localparam logic [3:0] OP_UNMASK   = 4'hA;
    localparam logic [3:0] OP_MCLR     = 4'hD;
    localparam logic [3:0] OP_IDLE     = 4'hF;

    localparam int MB_IO   = 0;
    localparam int MB_XFER = 2;
    localparam int MB_READ = 3;
    localparam int MB_WORD = 6;

    typedef struct packed {
        logic [23:0] addr;
        logic [15:0] cnt;
        logic [15:0] iop;
        logic [7:0]  mode;
        logic        mask;
        logic        tc;
    } chan_st_t;

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] ch;
        logic [1:0] ptr;
    } seq_st_t;

    function automatic logic [1:0] wr_len(input logic [3:0] op);
        case (op)
            OP_SET_IO:   return 2'd2;
            OP_SET_ADDR: return 2'd3;
            OP_SET_CNT:  return 2'd2;
            OP_SET_MODE: return 2'd1;
            default:     return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] rd_len(input logic [3:0] op);
        case (op)
            OP_GET_ADDR: return 2'd3;
            OP_GET_CNT:  return 2'd2;
            OP_GET_STAT: return 2'd1;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_wdata,
    input  logic       dat_we,
    input  logic       dat_re,
    output logic [3:0] op_o,
    output logic [3:0] ch_o,
    output logic [1:0] ptr_o,
    output logic       wr_fire_o
);

    seq_st_t seq_d, seq_q;
    logic    rd_adv;

    always_comb begin
        seq_d     = seq_q;
        wr_fire_o = !cmd_we && dat_we && (seq_q.ptr < wr_len(seq_q.op));
        rd_adv    = !cmd_we && !dat_we && dat_re && (seq_q.ptr < rd_len(seq_q.op));
        if (cmd_we) begin
            seq_d.op  = cmd_wdata[7:4];
            seq_d.ch  = cmd_wdata[3:0];
            seq_d.ptr = 2'd0;
        end else if (wr_fire_o || rd_adv) begin
            seq_d.ptr = seq_q.ptr + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{op: OP_IDLE, ch: 4'd0, ptr: 2'd0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign op_o  = seq_q.op;
    assign ch_o  = seq_q.ch;
    assign ptr_o = seq_q.ptr;

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (seq_q.ptr == 2'd0)); // R1

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr,
    input  logic [3:0] wr_op,
    input  logic [1:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic       mask_set,
    input  logic       mask_clr,
    input  logic       stb,
    output chan_st_t   st_o
);

    chan_st_t ch_d, ch_q;
    logic     active;
    logic [23:0] step;

    always_comb begin
        ch_d   = ch_q;
        active = stb && !ch_q.mask && ch_q.mode[MB_XFER];
        step   = ch_q.mode[MB_WORD] ? 24'd2 : 24'd1;
        if (clr) begin
            ch_d      = '0;
            ch_d.mask = 1'b1;
        end else begin
            if (wr) begin
                case (wr_op)
                    OP_SET_ADDR: begin
                        case (wr_idx)
                            2'd0:    ch_d.addr[7:0]   = wr_data;
                            2'd1:    ch_d.addr[15:8]  = wr_data;
                            default: ch_d.addr[23:16] = wr_data;
                        endcase
                    end
                    OP_SET_CNT: begin
                        if (wr_idx == 2'd0) ch_d.cnt[7:0]  = wr_data;
                        else                ch_d.cnt[15:8] = wr_data;
                        ch_d.tc = 1'b0;
                    end
                    OP_SET_IO: begin
                        if (wr_idx == 2'd0) ch_d.iop[7:0]  = wr_data;
                        else                ch_d.iop[15:8] = wr_data;
                    end
                    OP_SET_MODE: ch_d.mode = wr_data;
                    default: ;
                endcase
            end else if (active) begin
                ch_d.addr = ch_q.addr + step;
                ch_d.cnt  = ch_q.cnt - 16'd1;
                if (ch_q.cnt == 16'd0) ch_d.tc = 1'b1;
            end
            if (mask_set)      ch_d.mask = 1'b1;
            else if (mask_clr) ch_d.mask = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q      <= '0;
            ch_q.mask <= 1'b1;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign st_o = ch_q;

    AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.mask && !wr && !clr) |=> ($stable(ch_q.addr) && $stable(ch_q.cnt))); // R10
    AST_TC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !wr && !clr && !ch_q.mask && ch_q.mode[MB_XFER] && ch_q.cnt == 16'd0)
        |=> (ch_q.tc && ch_q.cnt == 16'hFFFF)); // R11
    AST_CLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ch_q.mask && !ch_q.tc && ch_q.addr == 24'd0 && ch_q.cnt == 16'd0)); // R9
    AST_WR_BEATS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && stb && !clr && wr_op == OP_SET_ADDR) |=> $stable(ch_q.cnt)); // R12

endmodule

// File: rtl/dmac_cmd_port.sv
module dmac_cmd_port
    import dmac_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_we,
    input  logic [7:0]     cmd_wdata,
    input  logic           dat_we,
    input  logic [7:0]     dat_wdata,
    input  logic           dat_re,
    output logic [7:0]     dat_rdata,
    input  logic           xfer_stb,
    input  logic [CHW-1:0] xfer_chan,
    output logic           eng_go,
    output logic           eng_word,
    output logic           eng_read,
    output logic           eng_io,
    output logic [15:0]    eng_ioport,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] tc_o
);

    logic [3:0] seq_op, seq_ch;
    logic [1:0] seq_ptr;
    logic       wr_fire;
    chan_st_t   st [NCH];
    chan_st_t   cur, eng;
    logic       mclr;

    dmac_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .dat_we    (dat_we),
        .dat_re    (dat_re),
        .op_o      (seq_op),
        .ch_o      (seq_ch),
        .ptr_o     (seq_ptr),
        .wr_fire_o (wr_fire)
    );

    assign mclr = cmd_we && (cmd_wdata[7:4] == OP_MCLR);

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        dmac_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (mclr),
            .wr       (wr_fire && (seq_ch == 4'(gi))),
            .wr_op    (seq_op),
            .wr_idx   (seq_ptr),
            .wr_data  (dat_wdata),
            .mask_set (cmd_we && cmd_wdata[7:4] == OP_MASK   && cmd_wdata[3:0] == 4'(gi)),
            .mask_clr (cmd_we && cmd_wdata[7:4] == OP_UNMASK && cmd_wdata[3:0] == 4'(gi)),
            .stb      (xfer_stb && (xfer_chan == CHW'(gi))),
            .st_o     (st[gi])
        );
        assign mask_o[gi] = st[gi].mask;
        assign tc_o[gi]   = st[gi].tc;
    end

    always_comb begin
        cur = '0;
        eng = '0;
        for (int i = 0; i < NCH; i++) begin
            if (seq_ch == 4'(i))      cur = st[i];
            if (xfer_chan == CHW'(i)) eng = st[i];
        end
    end

    always_comb begin
        dat_rdata = 8'h00;
        if (seq_ptr < rd_len(seq_op)) begin
            case (seq_op)
                OP_GET_ADDR: begin
                    case (seq_ptr)
                        2'd0:    dat_rdata = cur.addr[7:0];
                        2'd1:    dat_rdata = cur.addr[15:8];
                        default: dat_rdata = cur.addr[23:16];
                    endcase
                end
                OP_GET_CNT:  dat_rdata = (seq_ptr == 2'd0) ? cur.cnt[7:0] : cur.cnt[15:8];
                OP_GET_STAT: dat_rdata = {6'd0, cur.tc, cur.mask};
                default: ;
            endcase
        end
    end

    assign eng_go     = !eng.mask && eng.mode[MB_XFER];
    assign eng_word   = eng.mode[MB_WORD];
    assign eng_read   = eng.mode[MB_READ];
    assign eng_io     = eng.mode[MB_IO];
    assign eng_ioport = eng.iop;

    AST_MCLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (&mask_o && tc_o == '0)); // R9
    AST_MASK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[7:4] == OP_MASK && cmd_wdata[3:0] == 4'd0) |=> mask_o[0]); // R8

endmodule

// File: tb/dmac_cmd_port_bench.sv
`timescale 1ns/1ps
module dmac_cmd_port_bench;
    localparam int NCH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = 8'h00;
    logic       dat_re = 1'b0;
    logic [7:0] dat_rdata;
    logic       xfer_stb = 1'b0;
    logic [3:0] xfer_chan = 4'd0;
    logic       eng_go, eng_word, eng_read, eng_io;
    logic [15:0] eng_ioport;
    logic [NCH-1:0] mask_o, tc_o;

    int nchk = 0;
    int nbad = 0;
    logic [23:0] exp_addr [NCH];
    logic [15:0] exp_cnt  [NCH];
    logic        exp_word [NCH];

    always #4 clk = ~clk;

    dmac_cmd_port #(.NCH(NCH)) u_dmac_cmd_port (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re), .dat_rdata(dat_rdata),
        .xfer_stb(xfer_stb), .xfer_chan(xfer_chan), .eng_go(eng_go), .eng_word(eng_word),
        .eng_read(eng_read), .eng_io(eng_io), .eng_ioport(eng_ioport),
        .mask_o(mask_o), .tc_o(tc_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nbad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input logic [3:0] op, input logic [3:0] ch);
        cmd_we = 1'b1; cmd_wdata = {op, ch};
        tick();
        cmd_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        dat_we = 1'b1; dat_wdata = b;
        tick();
        dat_we = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        b = dat_rdata;
        dat_re = 1'b1;
        tick();
        dat_re = 1'b0;
    endtask

    task automatic stb(input logic [3:0] ch);
        xfer_stb = 1'b1; xfer_chan = ch;
        tick();
        xfer_stb = 1'b0;
    endtask

    task automatic get_addr(input logic [3:0] ch, output logic [23:0] a);
        logic [7:0] b0, b1, b2;
        cmd(4'h3, ch);
        rd(b0); rd(b1); rd(b2);
        a = {b2, b1, b0};
    endtask

    task automatic get_cnt(input logic [3:0] ch, output logic [15:0] c);
        logic [7:0] b0, b1;
        cmd(4'h5, ch);
        rd(b0); rd(b1);
        c = {b1, b0};
    endtask

    task automatic prog(input logic [3:0] ch, input logic [7:0] mode,
                        input logic [23:0] a, input logic [15:0] c);
        cmd(4'h9, ch);
        cmd(4'h7, ch); wr(mode);
        cmd(4'h2, ch); wr(a[7:0]); wr(a[15:8]); wr(a[23:16]);
        cmd(4'h4, ch); wr(c[7:0]); wr(c[15:8]);
        cmd(4'hA, ch);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        logic [23:0] a;
        logic [15:0] c;
        logic [7:0]  b;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R8: reset state
        chk("R8 reset masks", int'(mask_o), 16'hFFFF);
        chk("R11 reset tc", int'(tc_o), 0);

        // R2 R3 R4 R6: program and read back every channel
        for (int ch = 0; ch < NCH; ch++) begin
            exp_addr[ch] = 24'(32'h102030 + ch * 32'h010203);
            exp_cnt[ch]  = 16'(ch * 37 + 1);
            exp_word[ch] = ch[0];
            prog(4'(ch), ch[0] ? 8'h44 : 8'h04, exp_addr[ch], exp_cnt[ch]);
        end
        chk("R8 unmask all", int'(mask_o), 0);
        for (int ch = 0; ch < NCH; ch++) begin
            get_addr(4'(ch), a);
            chk("R2 R6 address readback", int'(a), int'(exp_addr[ch]));
            rd(b);
            chk("R6 read past field", int'(b), 0);
            get_cnt(4'(ch), c);
            chk("R3 R6 count readback", int'(c), int'(exp_cnt[ch]));
            cmd(4'h6, 4'(ch)); rd(b);
            chk("R7 status", int'(b), 0);
            xfer_chan = 4'(ch); #1;
            chk("R4 eng_word", int'(eng_word), int'(exp_word[ch]));
            chk("R4 eng_go", int'(eng_go), 1);
        end

        // R10: strobes step address and count
        for (int ch = 0; ch < NCH; ch++) begin
            for (int k = 0; k < ch % 3 + 1; k++) begin
                stb(4'(ch));
                exp_addr[ch] = exp_addr[ch] + (exp_word[ch] ? 24'd2 : 24'd1);
                exp_cnt[ch]  = exp_cnt[ch] - 16'd1;
            end
        end
        for (int ch = 0; ch < NCH; ch++) begin
            get_addr(4'(ch), a);
            chk("R10 address step", int'(a), int'(exp_addr[ch]));
            get_cnt(4'(ch), c);
            chk("R10 count step", int'(c), int'(exp_cnt[ch]));
        end

        // R8 R10: masked channel ignores strobes
        cmd(4'h9, 4'd5);
        chk("R8 mask set", int'(mask_o[5]), 1);
        stb(4'd5);
        get_addr(4'd5, a);
        chk("R10 masked no step", int'(a), int'(exp_addr[5]));
        cmd(4'hA, 4'd5);
        chk("R8 mask clear", int'(mask_o[5]), 0);

        // R10: transfer-disabled mode ignores strobes
        cmd(4'h7, 4'd6); wr(8'h00);
        stb(4'd6);
        get_cnt(4'd6, c);
        chk("R10 disabled no step", int'(c), int'(exp_cnt[6]));

        // R4: mode bits and I/O port on engine outputs
        cmd(4'h7, 4'd7); wr(8'h0D);
        cmd(4'h0, 4'd7); wr(8'hEF); wr(8'hBE);
        xfer_chan = 4'd7; #1;
        chk("R4 ioport", int'(eng_ioport), 16'hBEEF);
        chk("R4 read io go", int'({eng_read, eng_io, eng_go, eng_word}), 4'b1110);

        // R11 R3: terminal count on wrap, cleared by count write
        cmd(4'h4, 4'd2); wr(8'h01); wr(8'h00);
        stb(4'd2);
        chk("R11 no tc yet", int'(tc_o[2]), 0);
        stb(4'd2);
        chk("R11 tc on wrap", int'(tc_o[2]), 1);
        get_cnt(4'd2, c);
        chk("R11 wrapped count", int'(c), 16'hFFFF);
        cmd(4'h6, 4'd2); rd(b);
        chk("R7 status tc", int'(b), 8'h02);
        cmd(4'h4, 4'd2); wr(8'h10);
        chk("R3 tc cleared", int'(tc_o[2]), 0);

        // R5: bytes past field length ignored
        cmd(4'h4, 4'd8); wr(8'h34); wr(8'h12); wr(8'h99);
        get_cnt(4'd8, c);
        chk("R5 extra byte ignored", int'(c), 16'h1234);
        // R5: data after mask/unassigned opcodes ignored
        cmd(4'h9, 4'd8); wr(8'h55);
        cmd(4'h1, 4'd8); wr(8'h66);
        cmd(4'hA, 4'd8);
        get_addr(4'd8, a);
        chk("R5 stray data ignored", int'(a), int'(exp_addr[8]));
        get_cnt(4'd8, c);
        chk("R5 stray data count", int'(c), 16'h1234);

        // R1: new command restarts byte pointer
        cmd(4'h2, 4'd9); wr(8'h11);
        cmd(4'h2, 4'd9); wr(8'h22); wr(8'h33); wr(8'h44);
        get_addr(4'd9, a);
        chk("R1 pointer restart", int'(a), 24'h443322);

        // R12: data write beats strobe
        cmd(4'h2, 4'd3);
        dat_we = 1'b1; dat_wdata = 8'hAB; xfer_stb = 1'b1; xfer_chan = 4'd3;
        tick();
        dat_we = 1'b0; xfer_stb = 1'b0;
        get_addr(4'd3, a);
        chk("R12 write wins addr", int'(a), int'({exp_addr[3][23:8], 8'hAB}));
        get_cnt(4'd3, c);
        chk("R12 strobe dropped", int'(c), int'(exp_cnt[3]));

        // R9: master clear
        cmd(4'hD, 4'd0);
        chk("R9 all masked", int'(mask_o), 16'hFFFF);
        chk("R9 tc clear", int'(tc_o), 0);
        get_addr(4'd3, a);
        chk("R9 address zero", int'(a), 0);
        get_cnt(4'd8, c);
        chk("R9 count zero", int'(c), 0);
        xfer_chan = 4'd7; #1;
        chk("R9 ioport zero", int'(eng_ioport), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule